// File: doc/BRIEF.md
# Byte-Lane Distributed RAM with Address Hold

This block is a small single-port memory built from distributed storage. A word is split into byte lanes (two lanes of eight bits by default). On each rising clock edge the block registers the address, the write data, the lane enables and the write strobe. The array itself is written on the following falling edge, and only the lanes whose enable bit is set change. The read port has no output register. The output word always shows what the array holds at the registered address, so a write appears on the output as soon as the falling edge has stored it.

An address-hold input lets the surrounding logic freeze the registered address for as many cycles as it needs. Data, lane enables and write strobe are still sampled on every edge, so a write made while the address is held goes to the held location. Addresses wider than the depth wrap modulo the depth. The reset is asynchronous and active low. Its release is synchronised inside the block, and it clears the registered address and the registered write strobe. It does not clear the array.

Top module: `bytelane_dram`

## Requirements
- R1: With the write strobe high and byte enable 2'b11, both lanes of the addressed word take the input data. For example, data 16'hABCD yields 16'hABCD.
- R2: Byte enable 2'b10 writes only lane 1 (bits 15:8). Writing 16'hABCD into a word holding 16'hFFFF leaves 16'hABFF.
- R3: Byte enable 2'b01 writes only lane 0 (bits 7:0). Writing 16'hABCD into a word holding 16'hFFFF leaves 16'hFFCD.
- R4: With the write strobe high and byte enable 2'b00, the addressed word stays unchanged.
- R5: With the write strobe low, no lane changes, whatever the byte enable value.
- R6: The array is written on the falling clock edge that follows the rising edge on which the write was registered. Between those two edges the output still shows the old contents.
- R7: The read is asynchronous. Once the array changes, the output shows the new contents at the registered address with no further clock edge.
- R8: With address hold low, the address is registered on each rising edge, and the output shows that location during the same cycle.
- R9: With address hold high, the registered address keeps its previous value and the address input has no effect on the output.
- R10: Data, byte enable and write strobe are registered on every rising edge, even while the address is held. A write made during a hold therefore lands at the held location, and the location on the address input is left untouched.
- R11: Address input values at or above DEPTH select location (address mod DEPTH).
- R12: While reset is asserted, the registered address is 0 and the registered write strobe is low. No write takes place during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Inputs are registered on the rising edge; the array is written on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | ADDR_W (6) | Word address, wrapped modulo DEPTH |
| din | input | LANES*LANE_W (16) | Write data |
| wr_en | input | 1 | Write strobe |
| byte_en | input | LANES (2) | Per-lane write enable; bit i selects bits i*LANE_W and up |
| addr_stall | input | 1 | Address hold: when high, the registered address is kept |
| dout | output | LANES*LANE_W (16) | Asynchronous read of the array at the registered address |

## Verification
The bench builds the block with its defaults: DEPTH of 32, a 6-bit address, and two 8-bit lanes. With a 6-bit address, the upper half of the address space lies beyond the array, so wrap-around can be tested at the ports by writing through address 37 and reading back through address 5. Two lanes allow every byte-enable code to be applied over a 16'hFFFF background. The output is sampled both before and after the falling edge, which separates the moment of storage from the moment of address capture.

// File: rtl/bldram_pkg.sv
`timescale 1ns/1ps
package bldram_pkg;

  localparam int unsigned DEF_DEPTH  = 32;
  localparam int unsigned DEF_ADDR_W = 6;
  localparam int unsigned DEF_LANE_W = 8;
  localparam int unsigned DEF_LANES  = 2;

  // Byte-enable codes for the default two-lane word.
  typedef enum logic [1:0] {
    LANE_NONE  = 2'b00,
    LANE_LOW   = 2'b01,
    LANE_HIGH  = 2'b10,
    LANE_BOTH  = 2'b11
  } lane_code_e;

endpackage

// File: rtl/bldram_rst_sync.sv
`timescale 1ns/1ps
module bldram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/bldram_addr_stage.sv
`timescale 1ns/1ps
module bldram_addr_stage #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LANES-1:0]  lane_in,
  input  logic              we_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LANES-1:0]  lane_q,
  output logic              we_q
);

  logic [ADDR_W-1:0] addr_d;

  // Address clock enable: hold the previous address while disabled.
  always_comb begin
    if (addr_en) begin
      addr_d = addr_in;
    end else begin
      addr_d = addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      data_q <= '0;
      lane_q <= '0;
      we_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_in;
      lane_q <= lane_in;
      we_q   <= we_in;
    end
  end

endmodule

// File: rtl/bldram_lane_bank.sv
`timescale 1ns/1ps
module bldram_lane_bank #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              we,
  input  logic [LANES-1:0]  lane_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic              lane_we;

    assign lane_we = we & lane_sel[g];

    // Falling-edge write of this lane only.
    always_ff @(negedge clk) begin
      if (lane_we) begin
        store[idx] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    // Unregistered read.
    assign rdata[g*LANE_W +: LANE_W] = store[idx];
  end

endmodule

// File: rtl/bytelane_dram.sv
`timescale 1ns/1ps
module bytelane_dram
  import bldram_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_en,
  input  logic [LANES-1:0]  byte_en,
  input  logic              addr_stall,
  output logic [DATA_W-1:0] dout
);

  logic              rst_q_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic [LANES-1:0]  be_q;
  logic              we_q;
  logic [IDX_W-1:0]  idx;

  function automatic logic [IDX_W-1:0] wrap_index(input logic [ADDR_W-1:0] a);
    return IDX_W'(32'(a) % DEPTH);
  endfunction

  bldram_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bldram_addr_stage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_stage (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .addr_en (~addr_stall),
    .addr_in (addr),
    .data_in (din),
    .lane_in (byte_en),
    .we_in   (wr_en),
    .addr_q  (addr_q),
    .data_q  (din_q),
    .lane_q  (be_q),
    .we_q    (we_q)
  );

  assign idx = wrap_index(addr_q);

  bldram_lane_bank #(
    .DEPTH  (DEPTH),
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_bank (
    .clk      (clk),
    .idx      (idx),
    .we       (we_q),
    .lane_sel (be_q),
    .wdata    (din_q),
    .rdata    (dout)
  );

endmodule

// File: rtl/bytelane_dram_chk.sv
`timescale 1ns/1ps
module bytelane_dram_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_stall,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] din_q,
  input logic [LANES-1:0]  be_q,
  input logic              we_q,
  input logic [DATA_W-1:0] dout
);

  // R8
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !addr_stall |=> addr_q == $past(addr));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    addr_stall |=> $stable(addr_q));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R1 R2 R3 R6 R7 R10: an enabled lane shows the registered data after the falling edge
    lane_written_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (we_q && be_q[g]) |-> dout[g*LANE_W +: LANE_W] == din_q[g*LANE_W +: LANE_W]);

    // R4 R5: a lane that is not enabled keeps its contents at an unchanged address
    lane_kept_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (!(we_q && be_q[g]) && addr_q == $past(addr_q))
        |-> dout[g*LANE_W +: LANE_W] == $past(dout[g*LANE_W +: LANE_W]));
  end

  // R12
  always @(posedge clk) begin
    if (!rst_q_n) begin
      reset_clear_chk: assert (addr_q == '0 && !we_q);
    end
  end

endmodule

bind bytelane_dram bytelane_dram_chk #(
  .ADDR_W (ADDR_W),
  .LANE_W (LANE_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .addr       (addr),
  .addr_stall (addr_stall),
  .addr_q     (addr_q),
  .din_q      (din_q),
  .be_q       (be_q),
  .we_q       (we_q),
  .dout       (dout)
);

// File: tb/bytelane_dram_bench.sv
`timescale 1ns/1ps
module bytelane_dram_bench;
  import bldram_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [5:0]  addr;
  logic [15:0] din;
  logic        wr_en;
  logic [1:0]  byte_en;
  logic        addr_stall;
  logic [15:0] dout;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          finished;

  bytelane_dram u_bytelane_dram (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .din        (din),
    .wr_en      (wr_en),
    .byte_en    (byte_en),
    .addr_stall (addr_stall),
    .dout       (dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: inputs set mid-cycle; pre = output after the rising edge,
  // post = output just after the following falling edge.
  task automatic access(input logic [5:0] a, input logic [15:0] d, input logic [1:0] be,
                        input logic we, input logic st,
                        output logic [15:0] pre, output logic [15:0] post);
    @(negedge clk); #1;
    addr = a; din = d; byte_en = be; wr_en = we; addr_stall = st;
    @(posedge clk); #1;
    pre = dout;
    @(negedge clk); #0.5;
    post = dout;
    wr_en = 1'b0;
  endtask

  task automatic t_full_word;
    logic [15:0] p, q;
    access(6'd1, 16'hFFFF, LANE_BOTH, 1'b1, 1'b0, p, q);
    check("R1 fill", q, 16'hFFFF);
    access(6'd1, 16'hABCD, LANE_BOTH, 1'b1, 1'b0, p, q);
    check("R6 old before fall", p, 16'hFFFF);
    check("R1 both lanes", q, 16'hABCD);
  endtask

  task automatic t_upper;
    logic [15:0] p, q;
    access(6'd2, 16'hFFFF, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd2, 16'hABCD, LANE_HIGH, 1'b1, 1'b0, p, q);
    check("R6 upper pre", p, 16'hFFFF);
    check("R2 upper only", q, 16'hABFF);
  endtask

  task automatic t_lower;
    logic [15:0] p, q;
    access(6'd3, 16'hFFFF, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd3, 16'hABCD, LANE_LOW, 1'b1, 1'b0, p, q);
    check("R3 lower only", q, 16'hFFCD);
    // R7: value seen without another rising edge, still there a half cycle on
    #1;
    check("R7 async read", dout, 16'hFFCD);
  endtask

  task automatic t_no_lanes;
    logic [15:0] p, q;
    access(6'd4, 16'h1357, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd4, 16'h0000, LANE_NONE, 1'b1, 1'b0, p, q);
    check("R4 enable 00", q, 16'h1357);
    access(6'd4, 16'h0000, LANE_BOTH, 1'b0, 1'b0, p, q);
    check("R5 strobe low", q, 16'h1357);
  endtask

  task automatic t_addr_switch;
    logic [15:0] p, q;
    access(6'd1, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    check("R8 capture loc1", p, 16'hABCD);
    access(6'd2, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    check("R8 capture loc2", p, 16'hABFF);
  endtask

  task automatic t_stall;
    logic [15:0] p, q;
    access(6'd7, 16'hFFFF, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd9, 16'h1111, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd12, 16'h0000, LANE_NONE, 1'b0, 1'b1, p, q);
    check("R9 held address", p, 16'h1111);
    access(6'd7, 16'h2222, LANE_BOTH, 1'b1, 1'b1, p, q);
    check("R10 held pre", p, 16'h1111);
    check("R10 write to held", q, 16'h2222);
    access(6'd7, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    check("R10 input loc untouched", p, 16'hFFFF);
    access(6'd9, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    check("R9 released read", p, 16'h2222);
  endtask

  task automatic t_wrap;
    logic [15:0] p, q;
    access(6'd37, 16'h5A3C, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd5, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    check("R11 wrap 37->5", p, 16'h5A3C);
    access(6'd5, 16'h00C3, LANE_LOW, 1'b1, 1'b0, p, q);
    access(6'd37, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    check("R11 wrap 5->37", p, 16'h5AC3);
  endtask

  task automatic t_reset;
    logic [15:0] p, q;
    access(6'd0, 16'h5A5A, LANE_BOTH, 1'b1, 1'b0, p, q);
    access(6'd6, 16'h0000, LANE_NONE, 1'b0, 1'b0, p, q);
    @(negedge clk); #1;
    addr = 6'd3; din = 16'h0000; byte_en = LANE_BOTH; wr_en = 1'b1; addr_stall = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #0.5;
    check("R12 address zero, no write", dout, 16'h5A5A);
    wr_en = 1'b0;
    #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #0.5;
    check("R12 after release held at 0", dout, 16'h5A5A);
    addr_stall = 1'b0;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; addr = '0; din = '0; wr_en = 1'b0; byte_en = '0; addr_stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_full_word();
    t_upper();
    t_lower();
    t_no_lanes();
    t_addr_switch();
    t_stall();
    t_wrap();
    t_reset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule